// File: doc/BRIEF.md
# Programmable Event Counter with Qualifiers

This block is one programmable performance counter for a shared cache and request-arbitration subsystem. Every cycle it receives a set of raw event lanes. Each lane carries a valid bit, an 8-bit event code and an 8-bit attribute vector of one-hot sub-event bits. A configuration register selects one event code and a unit mask. The block works out how many lanes match in that cycle. For tracker-occupancy codes it takes the current queue depth instead of a lane count. That per-cycle figure then passes through a threshold compare, an optional inversion and an optional rising-edge detector before it is added to a wide counter.

Software reaches the block through a single register port. Select 0 addresses the configuration word and select 1 addresses the counter. Both can be read and written. The counter raises no interrupt, does not chain to other counters and wraps silently when it overflows.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the counter reads 0 and the configuration word reads 0, which means the counter is disabled.
- R2: With `reg_sel`=0 the register port holds the configuration word: bits 7:0 event code, 15:8 unit mask, 23:16 threshold, 24 edge mode, 25 invert, 26 enable, all higher bits reading 0. With `reg_sel`=1 the port holds the counter. A write takes effect at the next clock edge, and `reg_rdata` shows the selected register combinationally.
- R3: A counter write in the same cycle as a qualified event loads the written value and drops that cycle's increment. In a cycle that writes the configuration, the counter does not change.
- R4: While the enable bit is clear, the counter holds its value whatever the lanes carry.
- R5: A lane matches when it is valid, its code equals the selected code, and its attribute vector shares at least one set bit with the unit mask. With threshold 0 the counter adds the number of matching lanes each cycle.
- R6: For code 34h the unit mask holds line-state bits in 3:0 and request-type bits in 7:4. A lane matches only if it overlaps the mask in both halves.
- R7: For code 80h the counter adds `occ_trk`, and for code 83h it adds `occ_coh`, each cycle, but only when unit-mask bit 0 is set. For these two codes the event lanes are ignored.
- R8: With a nonzero threshold and invert clear, the counter adds 1 in each cycle whose per-cycle count is at least the threshold.
- R9: With a nonzero threshold and invert set, the counter adds 1 in each cycle whose per-cycle count is below the threshold. With threshold 0 the invert bit has no effect.
- R10: In edge mode the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold 0, the condition is a nonzero per-cycle count.
- R11: A configuration write marks the edge history as true. After such a write, an edge-mode count needs the condition to be seen false first.
- R12: The counter is 48 bits wide and wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | N_LANES | Per-lane event valid |
| ev_code | input | 8*N_LANES | Per-lane event code, lane i in bits 8i+7:8i |
| ev_attr | input | 8*N_LANES | Per-lane one-hot sub-event attribute bits |
| occ_trk | input | OCC_W | Memory-request tracker occupancy |
| occ_coh | input | OCC_W | Coherency tracker occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects configuration, 1 selects counter |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Selected register contents |

## Verification
The bench targets three kinds of corner case.

The first is the threshold boundary. A design that compares with strict greater-than would miss a count exactly equal to the threshold, and a design that honours invert with threshold 0 would add nothing where three lanes match.

The second is the edge detector. A design that resets edge history to false on a configuration write would count a condition that was already true at the time of the write, and a level-sensitive design would count every cycle of a held condition.

The third is the cache-lookup match, the occupancy codes and the 48-bit wrap. A design that ORs the two mask halves for code 34h would count lookups with the wrong request type. A design that reads the wrong occupancy input would add the other tracker's depth. A design with a narrow adder would not wrap to 2.

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int N_LANES     = 4,
  parameter int CNT_W       = 48,
  parameter int OCC_W       = 8,
  parameter logic [7:0] LOOKUP_CODE = 8'h34,
  parameter logic [7:0] OCC_TRK_CODE = 8'h80,
  parameter logic [7:0] OCC_COH_CODE = 8'h83
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LANES-1:0]   ev_valid,
  input  logic [8*N_LANES-1:0] ev_code,
  input  logic [8*N_LANES-1:0] ev_attr,
  input  logic [OCC_W-1:0]     occ_trk,
  input  logic [OCC_W-1:0]     occ_coh,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata
);
  localparam int LW = $clog2(N_LANES + 1);
  localparam int IW = (OCC_W > LW) ? OCC_W : LW;
  localparam int CW = (IW > 8) ? IW : 8;

  logic [7:0] sel_code, sel_mask, sel_thr;
  logic       sel_edge, sel_inv, sel_en;
  logic [CNT_W-1:0] count_q;
  logic       prev_q;

  logic [N_LANES-1:0] hit;
  logic [IW-1:0]      lane_cnt, per_cyc;
  logic               cond, rise;
  logic [CNT_W-1:0]   step;

  wire is_lookup = (sel_code == LOOKUP_CODE);
  wire is_trk    = (sel_code == OCC_TRK_CODE);
  wire is_coh    = (sel_code == OCC_COH_CODE);
  wire cfg_wr    = reg_wr && !reg_sel;
  wire cnt_wr    = reg_wr &&  reg_sel;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    wire [7:0] code_i = ev_code[8*i +: 8];
    wire [7:0] ovl    = ev_attr[8*i +: 8] & sel_mask;
    assign hit[i] = ev_valid[i] && (code_i == sel_code) &&
                    (is_lookup ? (|ovl[3:0] && |ovl[7:4]) : |ovl);
  end

  always_comb begin
    lane_cnt = '0;
    for (int i = 0; i < N_LANES; i++) lane_cnt = lane_cnt + IW'(hit[i]);
  end

  always_comb begin
    if (is_trk)      per_cyc = sel_mask[0] ? IW'(occ_trk) : '0;
    else if (is_coh) per_cyc = sel_mask[0] ? IW'(occ_coh) : '0;
    else             per_cyc = lane_cnt;
  end

  always_comb begin
    if (sel_thr == 8'd0) cond = (per_cyc != '0);
    else if (sel_inv)    cond = (CW'(per_cyc) <  CW'(sel_thr));
    else                 cond = (CW'(per_cyc) >= CW'(sel_thr));
  end

  assign rise = cond && !prev_q;

  always_comb begin
    if (sel_edge)              step = CNT_W'(rise);
    else if (sel_thr == 8'd0)  step = CNT_W'(per_cyc);
    else                       step = CNT_W'(cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_code <= '0; sel_mask <= '0; sel_thr <= '0;
      sel_edge <= 1'b0; sel_inv <= 1'b0; sel_en <= 1'b0;
    end else if (cfg_wr) begin
      sel_code <= reg_wdata[7:0];
      sel_mask <= reg_wdata[15:8];
      sel_thr  <= reg_wdata[23:16];
      sel_edge <= reg_wdata[24];
      sel_inv  <= reg_wdata[25];
      sel_en   <= reg_wdata[26];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (cnt_wr)  count_q <= reg_wdata;
    else if (!cfg_wr && sel_en) count_q <= count_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (cfg_wr)  prev_q <= 1'b1;
    else if (!sel_en) prev_q <= 1'b0;
    else              prev_q <= cond;
  end

  assign reg_rdata = reg_sel ? count_q
                   : CNT_W'({5'b0, sel_en, sel_inv, sel_edge, sel_thr, sel_mask, sel_code});

  assert_cnt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(reg_wdata)));

  assert_cfg_nocount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $stable(count_q));

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en && !reg_wr) |=> $stable(count_q));

  assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && !reg_wr && sel_thr != 8'd0) |=> ((count_q - $past(count_q)) <= CNT_W'(1)));

  assert_edge_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && sel_edge && !reg_wr && prev_q) |=> $stable(count_q));

  assert_edge_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && sel_edge && !reg_wr) |=> ((count_q - $past(count_q)) <= CNT_W'(1)));

  assert_cfg_history_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> prev_q);
endmodule

// File: tb/perf_event_counter_bench.sv
module perf_event_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int CW = 48;
  localparam int NV = 14;

  // per vector: config word, lane valids, codes, attributes, occupancies, expected increment
  localparam logic [31:0] V_CFG  [NV] = '{
    32'h0400_0122, 32'h0400_0F22, 32'h0400_0F22, 32'h0400_0122,  // R5
    32'h0400_1134, 32'h0400_0134,                                // R6
    32'h0400_0180, 32'h0400_0183,                                // R7
    32'h0402_0F22, 32'h0403_0F22,                                // R8
    32'h0603_0F22, 32'h0602_0F22, 32'h0600_0F22,                 // R9
    32'h0000_0F22};                                              // R4
  localparam logic [3:0]  V_VLD  [NV] = '{4'hF,4'hF,4'h5,4'hF, 4'hF,4'hF, 4'hF,4'hF,
                                          4'hF,4'h3, 4'h3,4'hF,4'h7, 4'hF};
  localparam logic [31:0] V_CODE [NV] = '{32'h22222222,32'h22222222,32'h22222222,32'h34343434,
                                          32'h34343434,32'h34343434,32'h80808080,32'h83838383,
                                          32'h22222222,32'h22222222,32'h22222222,32'h22222222,
                                          32'h22222222,32'h22222222};
  localparam logic [31:0] V_ATTR [NV] = '{32'h04010201,32'h04010201,32'h04010201,32'h01010101,
                                          32'h12012111,32'h11111111,32'h01010101,32'h01010101,
                                          32'h08040201,32'h08040201,32'h08040201,32'h08040201,
                                          32'h08040201,32'h08040201};
  localparam logic [7:0]  V_TRK  [NV] = '{0,0,0,0, 0,0, 55,9, 0,0, 0,0,0, 0};
  localparam logic [7:0]  V_COH  [NV] = '{0,0,0,0, 0,0, 3,5,  0,0, 0,0,0, 0};
  localparam logic [7:0]  V_EXP  [NV] = '{2,4,2,0, 1,0, 55,5, 1,0, 1,0,3, 0};
  localparam string       V_TAG  [NV] = '{"R5","R5","R5","R5","R6","R6","R7","R7",
                                          "R8","R8","R9","R9","R9","R4"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0]   ev_valid = '0;
  logic [8*NL-1:0] ev_code = '0, ev_attr = '0;
  logic [7:0]      occ_trk = '0, occ_coh = '0;
  logic            reg_wr = 1'b0, reg_sel = 1'b0;
  logic [CW-1:0]   reg_wdata = '0;
  logic [CW-1:0]   reg_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  perf_event_counter u_perf_event_counter (
    .clk, .rst_n, .ev_valid, .ev_code, .ev_attr, .occ_trk, .occ_coh,
    .reg_wr, .reg_sel, .reg_wdata, .reg_rdata);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_lanes();
    ev_valid = '0; ev_code = '0; ev_attr = '0; occ_trk = '0; occ_coh = '0;
  endtask

  task automatic wr(input logic sel, input logic [CW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
  endtask

  task automatic quiet();
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [CW-1:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic match22(input logic [3:0] vld);
    ev_valid = vld; ev_code = 32'h22222222; ev_attr = 32'h08040201;
  endtask

  logic [CW-1:0] v;

  initial begin
    idle_lanes();
    repeat (3) @(negedge clk);
    #1; v = reg_rdata; check("R1 config after reset", v, '0);
    rd(1'b1, v); check("R1 counter after reset", v, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      idle_lanes();
      wr(1'b0, CW'(V_CFG[i]));
      wr(1'b1, '0);
      quiet();
      ev_valid = V_VLD[i]; ev_code = V_CODE[i]; ev_attr = V_ATTR[i];
      occ_trk = V_TRK[i]; occ_coh = V_COH[i];
      wr(1'b0, '0);
      idle_lanes();
      quiet();
      rd(1'b1, v);
      check(V_TAG[i], v, CW'(V_EXP[i]));
    end

    // R2 register port
    wr(1'b0, 48'hFFFF_FFFF_FFFF); quiet(); rd(1'b0, v);
    check("R2 config readback", v, 48'h0000_07FF_FFFF);
    wr(1'b1, 48'h0123_4567_89AB); quiet(); rd(1'b1, v);
    check("R2 counter readback", v, 48'h0123_4567_89AB);

    // R3 counter write wins over increment, config write blocks counting
    wr(1'b0, 48'h0400_0F22);
    wr(1'b1, 48'd100); match22(4'hF);
    quiet(); idle_lanes(); rd(1'b1, v);
    check("R3 write beats increment", v, 48'd100);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 48'h0400_0F22; match22(4'hF);
    quiet(); idle_lanes(); rd(1'b1, v);
    check("R3 no count in config write cycle", v, 48'd100);

    // R4 disable mid-run holds value
    wr(1'b0, 48'h0000_0F22); quiet(); match22(4'hF);
    repeat (3) @(negedge clk); idle_lanes(); rd(1'b1, v);
    check("R4 hold while disabled", v, 48'd100);

    // R12 wrap
    wr(1'b1, 48'hFFFF_FFFF_FFFE); wr(1'b0, 48'h0400_0F22);
    quiet(); match22(4'hF);
    wr(1'b0, '0); idle_lanes(); quiet(); rd(1'b1, v);
    check("R12 wrap modulo 2^48", v, 48'd2);

    // R10 edge, threshold 0, lane0 pattern 1 1 1 0 1 0 0 1 1
    wr(1'b0, 48'h0500_0122); wr(1'b1, '0); quiet();
    foreach (V_PAT1[k]) begin
      match22(V_PAT1[k] ? 4'h1 : 4'h0);
      @(negedge clk);
    end
    wr(1'b0, '0); idle_lanes(); quiet(); rd(1'b1, v);
    check("R10 edge rises thr0", v, 48'd3);

    // R10 edge with threshold 2, counts 4 4 1 3 3 0
    wr(1'b0, 48'h0502_0F22); wr(1'b1, '0); quiet();
    foreach (V_PAT2[k]) begin
      match22(V_PAT2[k]);
      @(negedge clk);
    end
    wr(1'b0, '0); idle_lanes(); quiet(); rd(1'b1, v);
    check("R10 edge rises thr2", v, 48'd2);

    // R11 config written while condition already true
    wr(1'b1, '0);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 48'h0500_0122; match22(4'h1);
    quiet();
    repeat (2) @(negedge clk);
    rd(1'b1, v); check("R11 no spurious edge count", v, 48'd0);
    idle_lanes(); @(negedge clk);
    match22(4'h1); @(negedge clk);
    wr(1'b0, '0); idle_lanes(); quiet(); rd(1'b1, v);
    check("R11 count after seen false", v, 48'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam bit       V_PAT1 [9] = '{1,1,1,0,1,0,0,1,1};
  localparam logic [3:0] V_PAT2 [6] = '{4'hF,4'hF,4'h1,4'h7,4'h7,4'h0};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule